// File: doc/BRIEF.md
# Cable Reflectometry Test Sequencer

This block times a cable-fault measurement on a single twisted-pair Ethernet line. Software programs two silence lengths, a transmit length and a drive level through a small register interface. It then sets a start bit. The sequencer walks through four phases in a fixed order: a quiet period before transmission, a modulated transmission, a quiet period after it, and a forced-link state in which the port stays without autonegotiation. When the forced-link state is reached, the block raises a done flag. It also raises a fail flag when the measurement could not be made.

The analog path and the correlation and peak search are not part of this block. Their result arrives on input pins and is captured when the transmission phase ends. It is captured as a fault word holding a peak-found flag, a sign that tells an open from a short, and a distance index. A link partner that is still active at that moment makes the measurement invalid. In that case the block reports fail, and the fault word reads zero.

All durations are counted on a microsecond tick input. Silence lengths are built from milliseconds of `TICKS_PER_MS` ticks each, so a test setup can shorten them by lowering that parameter.

Top module: `cable_refl_seq`

## Requirements
- R1: After reset:
  - the control word (address 0) reads 0;
  - the transmit-length register (address 3) reads 16000;
  - the tap word (address 2) reads 0x2404, that is first tap 4 in bits 6:0 and last tap 36 in bits 14:8, and `tap_first`/`tap_last` show 4 and 36;
  - `tx_en` and `forced_link` are low.
- R2: Writing address 0 with bit 15 set starts a test that runs the phases quiet-before, transmit, quiet-after, forced-link. A phase of N ticks lasts N+1 clock cycles when a tick is present every cycle.
- R3: The timing word (address 1) holds the pre-silence code in bits 1:0 and the post-silence code in bits 3:2. Codes 0, 1, 2 and 3 give 0, 10, 100 and 1000 ms, one ms being `TICKS_PER_MS` ticks. The word reads back with the same field positions.
- R4: The transmit phase lasts the 16-bit tick count held at address 3, and `tx_en` is high in that phase only.
- R5: Bit 12 of the timing word selects the drive level. `tx_level_hi` equals that bit while `tx_en` is high and is 0 otherwise.
- R6: On entering the forced-link phase, done (address 0 bit 1) is set and `forced_link` goes high. Both stay set until a soft reset or a new start.
- R7: The fault word (address 4) is captured when the transmit phase ends. It holds peak-found in bit 11, the sign in bit 10 (1 = open, 0 = short) and the 10-bit location in bits 9:0.
- R8: If `partner_active` is high when the transmit phase ends, the test finishes with fail (address 0 bit 0) set together with done, and the fault word reads 0.
- R9: A start written during the quiet or transmit phases is ignored. An accepted start clears done and fail.
- R10: A phase's counter advances only on clock cycles where `us_tick` is high.
- R11: Writing address 0 with bit 14 set (soft reset) returns the block to idle and clears done, fail, the fault word and `forced_link`. It wins over a start bit written with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle microsecond tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| partner_active | input | 1 | Link partner present; invalidates the measurement |
| peak_found | input | 1 | Reflection peak detected |
| peak_open | input | 1 | Peak sign, 1 = open, 0 = short |
| peak_pos | input | 10 | Peak location index |
| tx_en | output | 1 | Modulated transmission active |
| tx_level_hi | output | 1 | High drive level selected during transmission |
| forced_link | output | 1 | Forced-link phase reached |
| tap_first | output | 7 | First correlation tap index |
| tap_last | output | 7 | Last correlation tap index |

## Verification
The bench measures the length of each phase in cycles. It does this for zero-length silence codes, the largest silence code, a zero and a full 65535-tick transmit length, and with the tick held low for a stretch. A design that loaded the wrong decade or counted free of the tick would show up as a wrong cycle count. Further runs cover:
- a second start written mid-run, which a design that restarted on it would answer with a longer quiet phase;
- a restart from the forced-link state, where stale done or fail flags would be caught;
- an active partner combined with a detected peak, which a design that still latched the peak would reveal through a nonzero fault word.

// File: rtl/cable_refl_seq.sv
module cable_refl_seq #(
  parameter int          TICKS_PER_MS = 1000,
  parameter logic [15:0] DUR_RESET    = 16'd16000,
  parameter logic [6:0]  TAP_FIRST_RESET = 7'd4,
  parameter logic [6:0]  TAP_LAST_RESET  = 7'd36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        partner_active,
  input  logic        peak_found,
  input  logic        peak_open,
  input  logic [9:0]  peak_pos,
  output logic        tx_en,
  output logic        tx_level_hi,
  output logic        forced_link,
  output logic [6:0]  tap_first,
  output logic [6:0]  tap_last
);
  localparam int MAX_SIL = 1000 * TICKS_PER_MS;
  localparam int SIL_W   = $clog2(MAX_SIL + 1);
  localparam int CW      = (SIL_W > 16) ? SIL_W : 16;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_TX, S_POST, S_LINK} state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic [1:0]     pre_code, post_code;
  logic           lvl_hi;
  logic [15:0]    dur;
  logic           done, fail, fail_pend;
  logic [11:0]    fstat;

  function automatic logic [CW-1:0] sil_len(input logic [1:0] code);
    case (code)
      2'd0:    sil_len = '0;
      2'd1:    sil_len = CW'(10 * TICKS_PER_MS);
      2'd2:    sil_len = CW'(100 * TICKS_PER_MS);
      default: sil_len = CW'(1000 * TICKS_PER_MS);
    endcase
  endfunction

  wire ctl_wr    = wr_en && (wr_addr == 3'd0);
  wire soft_rst  = ctl_wr && wr_data[14];
  wire running   = (st == S_PRE) || (st == S_TX) || (st == S_POST);
  wire start_acc = ctl_wr && wr_data[15] && !wr_data[14] && !running;
  wire cnt_zero  = (cnt == '0);

  assign tx_en       = (st == S_TX);
  assign tx_level_hi = tx_en && lvl_hi;
  assign forced_link = (st == S_LINK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      pre_code  <= 2'd0;
      post_code <= 2'd0;
      lvl_hi    <= 1'b0;
      dur       <= DUR_RESET;
      tap_first <= TAP_FIRST_RESET;
      tap_last  <= TAP_LAST_RESET;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_pend <= 1'b0;
      fstat     <= '0;
    end else begin
      if (wr_en && wr_addr == 3'd1) begin
        pre_code  <= wr_data[1:0];
        post_code <= wr_data[3:2];
        lvl_hi    <= wr_data[12];
      end
      if (wr_en && wr_addr == 3'd2) begin
        tap_first <= wr_data[6:0];
        tap_last  <= wr_data[14:8];
      end
      if (wr_en && wr_addr == 3'd3) dur <= wr_data;

      if (soft_rst) begin
        st        <= S_IDLE;
        cnt       <= '0;
        done      <= 1'b0;
        fail      <= 1'b0;
        fail_pend <= 1'b0;
        fstat     <= '0;
      end else if (start_acc) begin
        st        <= S_PRE;
        cnt       <= sil_len(pre_code);
        done      <= 1'b0;
        fail      <= 1'b0;
        fail_pend <= 1'b0;
        fstat     <= '0;
      end else begin
        case (st)
          S_PRE:
            if (cnt_zero) begin
              st  <= S_TX;
              cnt <= CW'(dur);
            end else if (us_tick) cnt <= cnt - 1'b1;
          S_TX:
            if (cnt_zero) begin
              st        <= S_POST;
              cnt       <= sil_len(post_code);
              fail_pend <= partner_active;
              fstat     <= partner_active ? 12'd0 : {peak_found, peak_open, peak_pos};
            end else if (us_tick) cnt <= cnt - 1'b1;
          S_POST:
            if (cnt_zero) begin
              st   <= S_LINK;
              done <= 1'b1;
              fail <= fail_pend;
            end else if (us_tick) cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {14'd0, done, fail};
      3'd1:    rd_data = {3'd0, lvl_hi, 8'd0, post_code, pre_code};
      3'd2:    rd_data = {1'b0, tap_last, 1'b0, tap_first};
      3'd3:    rd_data = dur;
      3'd4:    rd_data = {4'd0, fstat};
      default: rd_data = 16'd0;
    endcase
  end

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && ctl_wr && wr_data[15] && !wr_data[14]) |=> (st != S_PRE));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!done && !fail && st == S_PRE));

  p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !us_tick && !cnt_zero && !soft_rst) |=> ($stable(cnt) && st == $past(st)));

  p_fail_no_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fstat == 12'd0 && done));

  p_done_in_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> forced_link);

  p_tx_after_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(st) == S_PRE);

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st == S_IDLE && !done && !fail));
endmodule

// File: tb/tb_cable_refl_seq.sv
module tb_cable_refl_seq;
  localparam int TPM = 4;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic partner_active = 1'b0, peak_found = 1'b0, peak_open = 1'b0;
  logic [9:0] peak_pos = '0;
  logic tx_en, tx_level_hi, forced_link;
  logic [6:0] tap_first, tap_last;

  always #4 clk = ~clk;

  cable_refl_seq #(.TICKS_PER_MS(TPM)) dut (
    .clk, .rst_n, .us_tick, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .partner_active, .peak_found, .peak_open, .peak_pos,
    .tx_en, .tx_level_hi, .forced_link, .tap_first, .tap_last);

  typedef struct {
    int pre; int tx; int post; logic lvl; logic [1:0] df; logic [15:0] st;
  } exp_t;
  exp_t q[$];

  int total = 0, fails = 0;
  bit mon_busy = 1'b0;
  event start_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic int sil(input int code);
    case (code)
      0: sil = 0;
      1: sil = 10 * TPM;
      2: sil = 100 * TPM;
      default: sil = 1000 * TPM;
    endcase
  endfunction

  task automatic run(input int pre, input int post, input int d, input logic lvl,
                     input logic partner, input logic det, input logic sgn,
                     input logic [9:0] loc, input bit mid_start, input int stall);
    exp_t e;
    e.pre  = sil(pre) + 2 + stall;
    e.tx   = d + 1;
    e.post = sil(post) + 2;
    e.lvl  = lvl;
    e.df   = {1'b1, partner};
    e.st   = partner ? 16'd0 : {4'd0, det, sgn, loc};
    q.push_back(e);
    wr(3'd1, {3'd0, lvl, 8'd0, 2'(post), 2'(pre)});
    wr(3'd3, 16'(d));
    partner_active = partner; peak_found = det; peak_open = sgn; peak_pos = loc;
    mon_busy = 1'b1;
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h8000; -> start_ev;
    @(negedge clk); wr_en = 1'b0;
    if (mid_start) begin
      repeat (2) @(negedge clk);
      wr(3'd0, 16'h8000);
    end
    if (stall > 0) begin
      @(negedge clk); us_tick = 1'b0;
      repeat (stall) @(negedge clk);
      us_tick = 1'b1;
    end
    wait (!mon_busy);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      int n, m, k;
      bit lvl_ok;
      @(start_ev);
      e = q.pop_front();
      n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 1) begin
          rd_addr = 3'd0; #1;
          chk(rd_data[1:0] == 2'b00, "R9 flags cleared on start", rd_data[1:0], 0);
        end
      end while (!tx_en);
      chk(n == e.pre, "R3/R10 pre-silence cycles", n, e.pre);
      m = 1; lvl_ok = (tx_level_hi == e.lvl);
      forever begin
        @(negedge clk);
        if (!tx_en) break;
        m++;
        if (tx_level_hi != e.lvl) lvl_ok = 1'b0;
      end
      chk(m == e.tx, "R4 transmit cycles", m, e.tx);
      chk(lvl_ok, "R5 level during transmit", tx_level_hi, e.lvl);
      chk(!tx_level_hi, "R5 level low after transmit", tx_level_hi, 0);
      k = 1;
      while (!forced_link) begin @(negedge clk); k++; end
      chk(k == e.post, "R3 post-silence cycles", k, e.post);
      rd_addr = 3'd0; #1;
      chk(rd_data[1:0] == e.df, "R6/R8 done and fail", rd_data[1:0], e.df);
      rd_addr = 3'd4; #1;
      chk(rd_data == e.st, "R7/R8 fault word", rd_data, e.st);
      repeat (3) @(negedge clk);
      chk(forced_link, "R6 forced link holds", forced_link, 1);
      mon_busy = 1'b0;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_addr = 3'd0; #1; chk(rd_data == 16'd0, "R1 control reset", rd_data, 0);
    rd_addr = 3'd3; #1; chk(rd_data == 16'd16000, "R1 duration reset", rd_data, 16000);
    rd_addr = 3'd2; #1; chk(rd_data == 16'h2404, "R1 tap word reset", rd_data, 16'h2404);
    chk(tap_first == 7'd4 && tap_last == 7'd36, "R1 tap outputs", {tap_last, tap_first}, {7'd36, 7'd4});
    chk(!tx_en && !forced_link, "R1 outputs idle", {tx_en, forced_link}, 0);

    wr(3'd1, 16'h1006);
    rd_addr = 3'd1; #1; chk(rd_data == 16'h1006, "R3 timing word readback", rd_data, 16'h1006);

    run(1, 0, 20, 1'b0, 1'b0, 1'b1, 1'b1, 10'd123, 1'b0, 0);   // R2 R7 open
    run(0, 1, 0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd1023, 1'b0, 0);   // R2 R7 short, restart from link
    run(2, 2, 15, 1'b1, 1'b1, 1'b1, 1'b1, 10'd55, 1'b0, 0);    // R8 partner
    run(1, 0, 10, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0, 1'b1, 30);    // R9 mid start, R10 stall
    run(3, 3, 65535, 1'b0, 1'b0, 1'b0, 1'b1, 10'd7, 1'b0, 0);  // R3 R4 extremes

    wr(3'd0, 16'hC000);
    @(negedge clk);
    chk(!forced_link, "R11 soft reset clears forced link", forced_link, 0);
    rd_addr = 3'd0; #1; chk(rd_data == 16'd0, "R11 soft reset clears flags", rd_data, 0);
    rd_addr = 3'd4; #1; chk(rd_data == 16'd0, "R11 soft reset clears fault word", rd_data, 0);
    repeat (5) @(negedge clk);
    chk(!tx_en && !forced_link, "R11 stays idle despite start bit", {tx_en, forced_link}, 0);

    wr(3'd2, 16'h1502);
    chk(tap_first == 7'd2 && tap_last == 7'd21, "R1 tap outputs follow writes", {tap_last, tap_first}, {7'd21, 7'd2});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule